// File: doc/BRIEF.md
# ASCII Hex Record Loader

This block sits between a byte-oriented serial receiver/transmitter pair and a programming back end. It takes in characters that carry ASCII hexadecimal programming records. Each character goes straight back out on the transmit side as an echo. The block decodes the record fields, keeps a running 8-bit checksum and holds the data bytes in a local buffer. No command reaches the back end before the last checksum digit has arrived and the sum has been found correct.

A record opens with `:`. Hex digits follow in this order: a byte count (2), a start address (4, most significant first), a record type (2), the data bytes (2 each) and a checksum (2). When the checksum is good, the block presents type, address, count and buffered data on a command port. It holds them until the back end signals completion, then sends `.` as its reply. A bad checksum, an oversized count or a checksum failure produces `X` and no command. A stray non-hex character inside a record drops the record without any reply.

Top module: `hexrec_loader`

## Requirements
- R1: Every character accepted on `rx_valid` is queued for transmission, and `tx_valid` is high in the cycle after the accepting edge. Echoes leave in the order the characters were received.
- R2: While the block waits for a record, every character other than `:` (0x3A) is echoed and has no other effect: no command and no status character.
- R3: A record is `:` followed by hex digits: count (2), address (4, high byte first), type (2), 2 per data byte and checksum (2). Digits `0-9`, `A-F` and `a-f` are accepted. Data byte i appears on `cmd_data[8*i+7:8*i]`.
- R4: `cmd_valid` rises in the cycle after the accepting edge of the final checksum digit, never earlier. It stays high with stable fields until `cmd_done` is sampled high. After that the status character `.` (0x2E) is transmitted.
- R5: A record is accepted when the 8-bit sum of all its decoded bytes, from count through checksum, is zero. Any other sum transmits `X` (0x58) and raises no command.
- R6: A byte count above `MAX_BYTES` (default 32) transmits `X` as soon as the count's second digit arrives. The rest of the record is ignored, and `cmd_count` never exceeds `MAX_BYTES`.
- R7: A non-hex character inside a record abandons the record without a status character. The block then waits for `:` again.
- R8: The record type is passed to `cmd_type` unchanged for data (0x00), end-of-file (0x01) and any other value.
- R9: When an echo and a status character are both pending, the echo goes first. While `tx_ready` is low, `tx_valid` and `tx_data` hold and nothing is sent.
- R10: After reset `tx_valid` and `cmd_valid` are low and the block waits for `:`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| tx_valid | output | 1 | Character offered to transmitter |
| tx_data | output | 8 | Character to transmit |
| tx_ready | input | 1 | Transmitter accepts `tx_data` this cycle |
| cmd_valid | output | 1 | Verified record presented to back end |
| cmd_type | output | 8 | Record type |
| cmd_addr | output | 16 | Record start address |
| cmd_count | output | $clog2(MAX_BYTES+1) | Number of data bytes |
| cmd_data | output | 8*MAX_BYTES | Buffered data, byte i at bits 8i+7..8i |
| cmd_done | input | 1 | Back end has finished the command |

## Verification
Some faults come from a wrong internal state. A misplaced field index or a stale half-byte flag shows up as a wrong `cmd_addr`, `cmd_type` or data byte when the command is presented. It can also cause a checksum verdict that flips from `.` to `X`. Either way it becomes visible within one record, a few dozen cycles after the faulty digit. A parser stuck in the wrong state either never raises `cmd_valid`, which is caught by the wait for the command, or returns status for garbage. An arbitration fault reorders or drops characters in the transmit log, which is compared character by character after every record.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;
  typedef enum logic [2:0] {
    PS_HUNT,
    PS_COUNT,
    PS_ADDR,
    PS_TYPE,
    PS_DATA,
    PS_SUM,
    PS_EXEC
  } pstate_e;

  localparam logic [7:0] CH_START = 8'h3A;  // ':'
  localparam logic [7:0] CH_OK    = 8'h2E;  // '.'
  localparam logic [7:0] CH_ERR   = 8'h58;  // 'X'
endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble (
  input  logic [7:0] chr,
  output logic       is_hex,
  output logic [3:0] nib
);
  always_comb begin
    is_hex = 1'b1;
    nib    = 4'd0;
    if (chr >= 8'h30 && chr <= 8'h39)      nib = chr[3:0];
    else if (chr >= 8'h41 && chr <= 8'h46) nib = chr[3:0] + 4'd9;
    else if (chr >= 8'h61 && chr <= 8'h66) nib = chr[3:0] + 4'd9;
    else                                   is_hex = 1'b0;
  end
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
  import hexrec_pkg::*;
#(
  parameter int MAX_BYTES = 32,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   cmd_done,
  output logic                   cmd_valid,
  output logic [7:0]             cmd_type,
  output logic [15:0]            cmd_addr,
  output logic [CW-1:0]          cmd_count,
  output logic [8*MAX_BYTES-1:0] cmd_data,
  output logic                   stat_set,
  output logic [7:0]             stat_chr
);
  localparam logic [7:0] MAX_B = 8'(MAX_BYTES);

  pstate_e       state_q, state_d;
  logic          half_q, half_d;
  logic [3:0]    hi_q, hi_d;
  logic [7:0]    sum_q, sum_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [15:0]   addr_q, addr_d;
  logic [7:0]    type_q, type_d;
  logic          buf_we;

  logic          is_hex;
  logic [3:0]    nib;
  logic [7:0]    byte_val;
  logic [7:0]    sum_new;

  hexrec_nibble u_nib (
    .chr    (rx_data),
    .is_hex (is_hex),
    .nib    (nib)
  );

  assign byte_val = {hi_q, nib};
  assign sum_new  = sum_q + byte_val;

  // next-state process
  always_comb begin
    state_d  = state_q;
    half_d   = half_q;
    hi_d     = hi_q;
    sum_d    = sum_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    addr_d   = addr_q;
    type_d   = type_q;
    buf_we   = 1'b0;
    stat_set = 1'b0;
    stat_chr = CH_OK;
    case (state_q)
      PS_HUNT: begin
        if (rx_valid && rx_data == CH_START) begin
          state_d = PS_COUNT;
          half_d  = 1'b0;
          sum_d   = 8'd0;
          idx_d   = '0;
        end
      end
      PS_EXEC: begin
        if (cmd_done) begin
          state_d  = PS_HUNT;
          stat_set = 1'b1;
          stat_chr = CH_OK;
        end
      end
      default: begin
        if (rx_valid) begin
          if (!is_hex) begin
            state_d = PS_HUNT;
          end else if (!half_q) begin
            hi_d   = nib;
            half_d = 1'b1;
          end else begin
            half_d = 1'b0;
            sum_d  = sum_new;
            case (state_q)
              PS_COUNT: begin
                if (byte_val > MAX_B) begin
                  state_d  = PS_HUNT;
                  stat_set = 1'b1;
                  stat_chr = CH_ERR;
                end else begin
                  cnt_d   = byte_val[CW-1:0];
                  idx_d   = '0;
                  state_d = PS_ADDR;
                end
              end
              PS_ADDR: begin
                if (idx_q == '0) begin
                  addr_d[15:8] = byte_val;
                  idx_d        = CW'(1);
                end else begin
                  addr_d[7:0] = byte_val;
                  state_d     = PS_TYPE;
                end
              end
              PS_TYPE: begin
                type_d  = byte_val;
                idx_d   = '0;
                state_d = (cnt_q == '0) ? PS_SUM : PS_DATA;
              end
              PS_DATA: begin
                buf_we = 1'b1;
                idx_d  = idx_q + CW'(1);
                if (idx_q == cnt_q - CW'(1)) state_d = PS_SUM;
              end
              PS_SUM: begin
                if (sum_new == 8'd0) begin
                  state_d = PS_EXEC;
                end else begin
                  state_d  = PS_HUNT;
                  stat_set = 1'b1;
                  stat_chr = CH_ERR;
                end
              end
              default: state_d = PS_HUNT;
            endcase
          end
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_HUNT;
      half_q  <= 1'b0;
      hi_q    <= 4'd0;
      sum_q   <= 8'd0;
      cnt_q   <= '0;
      idx_q   <= '0;
      addr_q  <= 16'd0;
      type_q  <= 8'd0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
      hi_q    <= hi_d;
      sum_q   <= sum_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      type_q  <= type_d;
    end
  end

  // data buffer, one enabled register per byte slot
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_buf
    logic [7:0] slot_q;
    logic       slot_en;
    assign slot_en = buf_we && (idx_q == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= 8'd0;
      else if (slot_en) slot_q <= byte_val;
    end
    assign cmd_data[8*g +: 8] = slot_q;
  end

  assign cmd_valid = (state_q == PS_EXEC);
  assign cmd_type  = type_q;
  assign cmd_addr  = addr_q;
  assign cmd_count = cnt_q;
endmodule

// File: rtl/hexrec_txarb.sv
module hexrec_txarb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       echo_set,
  input  logic [7:0] echo_chr,
  input  logic       stat_set,
  input  logic [7:0] stat_chr,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  logic       echo_pend_q, echo_pend_d;
  logic       stat_pend_q, stat_pend_d;
  logic [7:0] echo_q, stat_q;
  logic       take_echo, take_stat;

  assign take_echo = tx_ready && echo_pend_q;
  assign take_stat = tx_ready && !echo_pend_q && stat_pend_q;

  always_comb begin
    echo_pend_d = echo_pend_q;
    stat_pend_d = stat_pend_q;
    if (echo_set)       echo_pend_d = 1'b1;
    else if (take_echo) echo_pend_d = 1'b0;
    if (stat_set)       stat_pend_d = 1'b1;
    else if (take_stat) stat_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_pend_q <= 1'b0;
      stat_pend_q <= 1'b0;
      echo_q      <= 8'd0;
      stat_q      <= 8'd0;
    end else begin
      echo_pend_q <= echo_pend_d;
      stat_pend_q <= stat_pend_d;
      if (echo_set) echo_q <= echo_chr;
      if (stat_set) stat_q <= stat_chr;
    end
  end

  assign tx_valid = echo_pend_q || stat_pend_q;
  assign tx_data  = echo_pend_q ? echo_q : stat_q;
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader #(
  parameter int MAX_BYTES = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rx_valid,
  input  logic [7:0]                         rx_data,
  output logic                               tx_valid,
  output logic [7:0]                         tx_data,
  input  logic                               tx_ready,
  output logic                               cmd_valid,
  output logic [7:0]                         cmd_type,
  output logic [15:0]                        cmd_addr,
  output logic [$clog2(MAX_BYTES+1)-1:0]     cmd_count,
  output logic [8*MAX_BYTES-1:0]             cmd_data,
  input  logic                               cmd_done
);
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  logic       stat_set;
  logic [7:0] stat_chr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  hexrec_parser #(.MAX_BYTES(MAX_BYTES)) u_parser (
    .clk       (clk),
    .rst_n     (rst_sn),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .cmd_done  (cmd_done),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .cmd_addr  (cmd_addr),
    .cmd_count (cmd_count),
    .cmd_data  (cmd_data),
    .stat_set  (stat_set),
    .stat_chr  (stat_chr)
  );

  hexrec_txarb u_txarb (
    .clk      (clk),
    .rst_n    (rst_sn),
    .echo_set (rx_valid),
    .echo_chr (rx_data),
    .stat_set (stat_set),
    .stat_chr (stat_chr),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk #(
  parameter int MAX_BYTES = 32,
  localparam int CW = $clog2(MAX_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          rx_valid,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_ready,
  input logic          cmd_valid,
  input logic [7:0]    cmd_type,
  input logic [15:0]   cmd_addr,
  input logic [CW-1:0] cmd_count,
  input logic          cmd_done
);
  // R1
  echo_follows_rx_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_valid |=> tx_valid);

  // R4
  cmd_held_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_addr) &&
                                $stable(cmd_type) && $stable(cmd_count));

  // R4
  cmd_after_char_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(cmd_valid) |-> $past(rx_valid));

  // R9
  tx_held_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid |-> cmd_count <= CW'(MAX_BYTES));
endmodule

bind hexrec_loader hexrec_loader_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .rx_valid  (rx_valid),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_ready  (tx_ready),
  .cmd_valid (cmd_valid),
  .cmd_type  (cmd_type),
  .cmd_addr  (cmd_addr),
  .cmd_count (cmd_count),
  .cmd_done  (cmd_done)
);

// File: tb/tb_hexrec_loader.sv
module tb_hexrec_loader;
  localparam int MAXB = 32;
  localparam int CW   = $clog2(MAXB + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rx_valid;
  logic [7:0]        rx_data;
  logic              tx_valid;
  logic [7:0]        tx_data;
  logic              tx_ready;
  logic              cmd_valid;
  logic [7:0]        cmd_type;
  logic [15:0]       cmd_addr;
  logic [CW-1:0]     cmd_count;
  logic [8*MAXB-1:0] cmd_data;
  logic              cmd_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] tx_log [0:255];
  logic [7:0] exp_log [0:255];
  int tx_n = 0;
  int exp_n = 0;
  bit cmd_seen = 0;

  always #2.5 clk = ~clk;

  hexrec_loader #(.MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cmd_data(cmd_data), .cmd_done(cmd_done)
  );

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && tx_n < 256) begin
      tx_log[tx_n] = tx_data;
      tx_n++;
    end
    if (rst_n && cmd_valid) cmd_seen = 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic clear_logs();
    tx_n = 0; exp_n = 0; cmd_seen = 0;
  endtask

  task automatic push_exp(input logic [7:0] c);
    if (exp_n < 256) begin exp_log[exp_n] = c; exp_n++; end
  endtask

  task automatic check_log(input string tag);
    int bad = -1;
    if (tx_n == exp_n) begin
      for (int i = 0; i < exp_n; i++)
        if (bad < 0 && tx_log[i] !== exp_log[i]) bad = i;
      if (bad < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, tag, tx_log[bad], exp_log[bad]);
    end else begin
      check(1'b0, {tag, " length"}, tx_n, exp_n);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lc);
    if (n < 4'd10) return 8'h30 + {4'd0, n};
    return (lc ? 8'h61 : 8'h41) + {4'd0, n} - 8'd10;
  endfunction

  task automatic send_char(input logic [7:0] c);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = c;
    push_exp(c);
    @(posedge clk); #1;
    rx_valid = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_hex(input logic [7:0] b, input bit lc);
    send_char(hexc(b[7:4], lc));
    send_char(hexc(b[3:0], lc));
  endtask

  function automatic logic [7:0] dbyte(input int i, input int cnt);
    return 8'((i * 29 + cnt * 7 + 3) & 255);
  endfunction

  // full record; bad=1 corrupts the checksum
  task automatic run_record(input int cnt, input logic [15:0] addr,
                            input logic [7:0] typ, input bit bad, input bit lc);
    logic [7:0] sum;
    logic [7:0] cs;
    int wait_n;
    clear_logs();
    sum = 8'(cnt) + addr[15:8] + addr[7:0] + typ;
    send_char(8'h3A);
    send_hex(8'(cnt), lc);
    send_hex(addr[15:8], lc);
    send_hex(addr[7:0], lc);
    send_hex(typ, lc);
    for (int i = 0; i < cnt; i++) begin
      send_hex(dbyte(i, cnt), lc);
      sum = sum + dbyte(i, cnt);
    end
    cs = 8'd0 - sum;
    if (bad) cs = cs ^ 8'h01;
    send_char(hexc(cs[7:4], lc));
    // R4: no command before the final checksum digit
    check(!cmd_seen, "R4 early command", cmd_seen, 0);
    send_char(hexc(cs[3:0], lc));
    if (!bad) begin
      wait_n = 0;
      while (!cmd_valid && wait_n < 50) begin @(negedge clk); wait_n++; end
      check(cmd_valid, "R4 command raised", cmd_valid, 1);
      check(cmd_type == typ, "R8 type", cmd_type, typ);
      check(cmd_addr == addr, "R3 address", cmd_addr, addr);
      check(int'(cmd_count) == cnt, "R3 count", cmd_count, cnt);
      for (int i = 0; i < cnt; i++)
        check(cmd_data[8*i +: 8] == dbyte(i, cnt), "R3 data byte",
              cmd_data[8*i +: 8], dbyte(i, cnt));
      repeat (3) @(posedge clk);
      check(cmd_valid, "R4 command held", cmd_valid, 1);
      @(posedge clk); #1 cmd_done = 1'b1;
      @(posedge clk); #1 cmd_done = 1'b0;
      push_exp(8'h2E);
      repeat (10) @(posedge clk);
      check(!cmd_valid, "R4 command released", cmd_valid, 0);
      check_log("R5 good record echo and status");
    end else begin
      repeat (10) @(posedge clk);
      check(!cmd_seen, "R5 bad checksum command", cmd_seen, 0);
      push_exp(8'h58);
      check_log("R5 bad checksum reply");
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = 8'd0; tx_ready = 1'b1; cmd_done = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10
    check(!tx_valid, "R10 tx_valid after reset", tx_valid, 0);
    check(!cmd_valid, "R10 cmd_valid after reset", cmd_valid, 0);

    // R2: junk outside a record, including hex digits
    clear_logs();
    send_char("a"); send_char("1"); send_char(" "); send_char("z"); send_char("F");
    repeat (10) @(posedge clk);
    check(!cmd_seen, "R2 junk command", cmd_seen, 0);
    check_log("R2 junk echo only");

    // R3 R5 sweep over every byte count, alternating digit case
    for (int c = 0; c <= MAXB; c++)
      run_record(c, 16'(c * 16'h0123 + 16'h8000), 8'h00, 1'b0, c[0]);

    // R8 type pass-through
    run_record(0, 16'h0000, 8'h01, 1'b0, 1'b0);
    run_record(2, 16'hBEEF, 8'h05, 1'b0, 1'b1);
    run_record(1, 16'h1234, 8'hFF, 1'b0, 1'b0);

    // R5 checksum failures
    run_record(0, 16'h0000, 8'h00, 1'b1, 1'b0);
    run_record(1, 16'h4321, 8'h00, 1'b1, 1'b0);
    run_record(MAXB, 16'hFFE0, 8'h03, 1'b1, 1'b1);

    // R6 oversize counts
    clear_logs();
    send_char(8'h3A); send_hex(8'(MAXB + 1), 1'b0);
    push_exp(8'h58);
    send_hex(8'h00, 1'b0); send_hex(8'h00, 1'b0);
    repeat (10) @(posedge clk);
    check(!cmd_seen, "R6 oversize command", cmd_seen, 0);
    check_log("R6 oversize reply");
    clear_logs();
    send_char(8'h3A); send_hex(8'hFF, 1'b1);
    push_exp(8'h58);
    repeat (10) @(posedge clk);
    check_log("R6 count FF reply");
    run_record(3, 16'h0300, 8'h00, 1'b0, 1'b0);

    // R7 non-hex abort mid-record, then recovery
    clear_logs();
    send_char(8'h3A); send_char("0"); send_char("G"); send_char("2");
    send_hex(8'h00, 1'b0); send_hex(8'h00, 1'b0);
    repeat (10) @(posedge clk);
    check(!cmd_seen, "R7 abort command", cmd_seen, 0);
    check_log("R7 abort no status");
    run_record(4, 16'h7000, 8'h00, 1'b0, 1'b1);

    // R9 echo before status, both held while tx_ready low
    clear_logs();
    send_char(8'h3A);
    send_hex(8'h00, 1'b0); send_hex(8'h00, 1'b0); send_hex(8'h00, 1'b0);
    send_hex(8'h00, 1'b0);
    send_char("0");
    tx_ready = 1'b0;
    send_char("1");
    repeat (10) @(posedge clk);
    check(tx_n == exp_n - 1, "R9 nothing sent while stalled", tx_n, exp_n - 1);
    check(tx_valid && tx_data == 8'h31, "R9 echo offered first", tx_data, 8'h31);
    @(posedge clk); #1 tx_ready = 1'b1;
    push_exp(8'h58);
    repeat (10) @(posedge clk);
    check_log("R9 echo then status order");
    // R1: echo appears the cycle after the accepting edge
    clear_logs();
    @(posedge clk); #1 rx_valid = 1'b1; rx_data = "q";
    @(posedge clk); #1 rx_valid = 1'b0;
    check(tx_valid && tx_data == "q", "R1 echo next cycle", tx_data, "q");
    repeat (5) @(posedge clk);

    finish_run();
  end
endmodule